// File: doc/BRIEF.md
# SDRAM Burst Data Path Sequencer

This block runs the column side of SDRAM read and write bursts once the target row is already open. A single command strobe carries the start column and the transfer direction. The block expands each command into one column access per cycle. The column addresses wrap inside an aligned block whose size is the programmed burst length. The wrap follows either a linear (sequential) order or an XOR (interleaved) order.

Write data moves straight through to the array in the same cycle as each beat, with per-byte enables. Read data comes back from the array one cycle after each access. The block then delays it so that it appears at the output a fixed CAS latency after the access, and blanks masked bytes. A new command takes over at once from any burst in progress. A stop input cuts a burst short, and reads and writes use different stop windows. A per-command option limits writes to one beat.

Top module: `sdr_burst_seq`

## Requirements
- R1: After reset, `mem_rd`, `mem_wr`, `wr_take` and `rd_valid` are all low while no command is given.
- R2: `bl_sel` codes 0, 1, 2 and 3 give 1, 2, 4 and 8 beats. Beat 0 is issued in the command cycle and the following beats in the cycles right after it, one per cycle.
- R3: With `burst_interleave`=0, beat i accesses column (start with its low log2(L) bits cleared) + ((start + i) mod L).
- R4: With `burst_interleave`=1, beat i keeps the start bits above the block and uses (start low bits XOR i) as its low bits.
- R5: A write beat drives `mem_wr`, `wr_take` and `mem_col` in its own cycle, and `mem_wdata` equals `wr_data` of that same cycle. Write data is therefore taken in the command cycle for beat 0.
- R6: During a write beat, `mem_be[b]` is the inverse of `byte_mask[b]`, so a masked byte in the array keeps its old value.
- R7: Read data for a beat appears on `rd_data` with `rd_valid` high exactly CL cycles after the beat's `mem_rd` cycle. CL is 3 when `cas_hi`=0 and 4 when `cas_hi`=1. The array returns `mem_rdata` one cycle after `mem_rd`.
- R8: `byte_mask` is sampled in a read beat's issue cycle. For a masked byte, that beat's output has `rd_oe[b]`=0 and the byte reads zero.
- R9: A command arriving during a burst ends the old burst in that cycle and issues beat 0 of the new burst in the same cycle.
- R10: A stop during a read burst issues no access in the stop cycle or after it. Data keeps arriving for CL-1 cycles after the stop (2 at CL 3, 3 at CL 4), and `rd_valid` is low from CL cycles after the stop.
- R11: A stop during a write burst still writes the beat of the stop cycle. No write happens from the next cycle on, and the remaining columns keep their contents.
- R12: When `single_write`=1, a write command transfers exactly one beat whatever `bl_sel` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Column command strobe |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| cmd_col | input | COL_W | Burst start column |
| cmd_stop | input | 1 | Burst stop (ignored when cmd_valid is high) |
| bl_sel | input | 2 | Burst length code: 0=1, 1=2, 2=4, 3=8 |
| burst_interleave | input | 1 | 1 = interleaved wrap order |
| cas_hi | input | 1 | 0 = CAS latency 3, 1 = CAS latency 4 |
| single_write | input | 1 | Writes transfer one beat only |
| byte_mask | input | NBYTE | Per-byte mask for the current beat |
| wr_data | input | DATA_W | Write data for the current beat |
| wr_take | output | 1 | Write data taken this cycle |
| mem_rd | output | 1 | Column read access to the array |
| mem_wr | output | 1 | Column write access to the array |
| mem_col | output | COL_W | Column of the current access |
| mem_wdata | output | DATA_W | Write data to the array |
| mem_be | output | NBYTE | Byte write enables to the array |
| mem_rdata | input | DATA_W | Array read data, one cycle after mem_rd |
| rd_valid | output | 1 | Read beat on rd_data |
| rd_oe | output | NBYTE | Per-byte output drive (0 = high impedance) |
| rd_data | output | DATA_W | Aligned read data, masked bytes zero |

## Verification
Reads run at every burst length, with start columns chosen so that the sequential and interleaved orders give different column lists. Start 1 in a block of four and start 5 in a block of eight are examples, and they also exercise the wrap inside the block. The same reads run at both latencies, so a data beat one cycle early or late is caught. Masked beats in reads and writes show whether the mask is applied to the correct beat and lane. Stops at the same beat, in reads at both latencies and in a write, separate the read window from the write window. Back-to-back commands show whether the old burst is cut in the same cycle.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;
    // Largest burst is 2**MAX_BL_LOG beats
    localparam int MAX_BL_LOG = 3;
    typedef logic [MAX_BL_LOG-1:0] beat_t;
    typedef enum logic [1:0] {
        BL_ONE   = 2'd0,
        BL_TWO   = 2'd1,
        BL_FOUR  = 2'd2,
        BL_EIGHT = 2'd3
    } bl_code_e;
endpackage

// File: rtl/sdr_col_gen.sv
module sdr_col_gen
    import sdr_seq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] start,
    input  beat_t            idx,
    input  beat_t            lenm1,
    input  logic             interleave,
    output logic [COL_W-1:0] col
);
    localparam int IW = MAX_BL_LOG;

    beat_t start_lo;
    beat_t seq_lo;
    beat_t xor_lo;
    beat_t wrap_lo;

    always_comb begin
        start_lo = start[IW-1:0];
        seq_lo   = start_lo + idx;
        xor_lo   = start_lo ^ idx;
        // bits inside the block move, bits above it stay at the start value
        wrap_lo  = (start_lo & ~lenm1) | ((interleave ? xor_lo : seq_lo) & lenm1);
        col      = {start[COL_W-1:IW], wrap_lo};
    end
endmodule

// File: rtl/sdr_rd_align.sv
module sdr_rd_align #(
    parameter int NBYTE = 4,
    parameter int CL_LO = 3,
    parameter int CL_HI = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cas_hi,
    input  logic                 iss_rd,
    input  logic [NBYTE-1:0]     iss_mask,
    input  logic [8*NBYTE-1:0]   mem_rdata,
    output logic                 rd_valid,
    output logic [NBYTE-1:0]     rd_oe,
    output logic [8*NBYTE-1:0]   rd_data
);
    localparam int DATA_W = 8 * NBYTE;

    typedef struct packed {
        logic [CL_HI-1:0]              vld;
        logic [CL_HI-1:0][NBYTE-1:0]   msk;
        logic [CL_HI-2:0][DATA_W-1:0]  dat;
    } pipe_t;

    pipe_t pipe_d, pipe_q;
    logic              vld_sel;
    logic [NBYTE-1:0]  msk_sel;
    logic [DATA_W-1:0] dat_sel;

    always_comb begin
        pipe_d     = pipe_q;
        pipe_d.vld = {pipe_q.vld[CL_HI-2:0], iss_rd};
        pipe_d.msk = {pipe_q.msk[CL_HI-2:0], iss_mask};
        pipe_d.dat = {pipe_q.dat[CL_HI-3:0], mem_rdata};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    // control stage k holds the beat issued k+1 cycles ago; data stage k holds k+2
    always_comb begin
        vld_sel = cas_hi ? pipe_q.vld[CL_HI-1] : pipe_q.vld[CL_LO-1];
        msk_sel = cas_hi ? pipe_q.msk[CL_HI-1] : pipe_q.msk[CL_LO-1];
        dat_sel = cas_hi ? pipe_q.dat[CL_HI-2] : pipe_q.dat[CL_LO-2];
    end

    assign rd_valid = vld_sel;

    for (genvar b = 0; b < NBYTE; b++) begin : g_lane
        assign rd_oe[b]           = vld_sel & ~msk_sel[b];
        assign rd_data[8*b +: 8]  = rd_oe[b] ? dat_sel[8*b +: 8] : 8'h00;
    end

    AST_RD_LAT_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_hi && rd_valid) |-> $past(iss_rd, CL_LO));  // R7
    AST_RD_LAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_hi && rd_valid) |-> $past(iss_rd, CL_HI));   // R7
endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
    import sdr_seq_pkg::*;
#(
    parameter int COL_W = 8,
    parameter int NBYTE = 4,
    parameter int CL_LO = 3,
    parameter int CL_HI = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic                 cmd_write,
    input  logic [COL_W-1:0]     cmd_col,
    input  logic                 cmd_stop,
    input  logic [1:0]           bl_sel,
    input  logic                 burst_interleave,
    input  logic                 cas_hi,
    input  logic                 single_write,
    input  logic [NBYTE-1:0]     byte_mask,
    input  logic [8*NBYTE-1:0]   wr_data,
    output logic                 wr_take,
    output logic                 mem_rd,
    output logic                 mem_wr,
    output logic [COL_W-1:0]     mem_col,
    output logic [8*NBYTE-1:0]   mem_wdata,
    output logic [NBYTE-1:0]     mem_be,
    input  logic [8*NBYTE-1:0]   mem_rdata,
    output logic                 rd_valid,
    output logic [NBYTE-1:0]     rd_oe,
    output logic [8*NBYTE-1:0]   rd_data
);
    localparam int IW = MAX_BL_LOG;

    typedef struct packed {
        logic             active;
        logic             wr;
        logic             il;
        logic [COL_W-1:0] start;
        beat_t            beat;
        beat_t            lenm1;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             iss;
    logic             iss_wr;
    logic [COL_W-1:0] gen_start;
    beat_t            gen_idx;
    beat_t            gen_lenm1;
    logic             gen_il;
    beat_t            new_lenm1;
    logic [IW:0]      len_full;

    always_comb begin
        len_full  = ({{IW{1'b0}}, 1'b1} << bl_sel) - 1'b1;
        new_lenm1 = (cmd_write && single_write) ? '0 : len_full[IW-1:0];

        ctl_d     = ctl_q;
        iss       = 1'b0;
        iss_wr    = ctl_q.wr;
        gen_start = ctl_q.start;
        gen_idx   = ctl_q.beat;
        gen_lenm1 = ctl_q.lenm1;
        gen_il    = ctl_q.il;

        if (cmd_valid) begin
            // a new command always takes over, even mid-burst
            iss          = 1'b1;
            iss_wr       = cmd_write;
            gen_start    = cmd_col;
            gen_idx      = '0;
            gen_lenm1    = new_lenm1;
            gen_il       = burst_interleave;
            ctl_d.active = (new_lenm1 != '0);
            ctl_d.wr     = cmd_write;
            ctl_d.il     = burst_interleave;
            ctl_d.start  = cmd_col;
            ctl_d.beat   = beat_t'(1);
            ctl_d.lenm1  = new_lenm1;
        end else if (ctl_q.active) begin
            if (cmd_stop) begin
                // writes keep the stop-cycle beat, reads drop it
                iss          = ctl_q.wr;
                ctl_d.active = 1'b0;
            end else begin
                iss          = 1'b1;
                ctl_d.beat   = ctl_q.beat + 1'b1;
                ctl_d.active = (ctl_q.beat != ctl_q.lenm1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    sdr_col_gen #(.COL_W(COL_W)) u_col_gen (
        .start      (gen_start),
        .idx        (gen_idx),
        .lenm1      (gen_lenm1),
        .interleave (gen_il),
        .col        (mem_col)
    );

    assign mem_rd    = iss & ~iss_wr;
    assign mem_wr    = iss & iss_wr;
    assign wr_take   = mem_wr;
    assign mem_wdata = wr_data;
    assign mem_be    = mem_wr ? ~byte_mask : '0;

    sdr_rd_align #(
        .NBYTE (NBYTE),
        .CL_LO (CL_LO),
        .CL_HI (CL_HI)
    ) u_rd_align (
        .clk       (clk),
        .rst_n     (rst_n),
        .cas_hi    (cas_hi),
        .iss_rd    (mem_rd),
        .iss_mask  (byte_mask),
        .mem_rdata (mem_rdata),
        .rd_valid  (rd_valid),
        .rd_oe     (rd_oe),
        .rd_data   (rd_data)
    );

    AST_WRAP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.active && !cmd_valid && (mem_rd || mem_wr)) |->
        ((mem_col & ~COL_W'(ctl_q.lenm1)) == (ctl_q.start & ~COL_W'(ctl_q.lenm1))));  // R3
    AST_NEW_CMD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (mem_col == cmd_col && mem_wr == cmd_write && mem_rd == !cmd_write));  // R9
    AST_RD_STOP_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stop && !cmd_valid) |-> !mem_rd);  // R10
    AST_WR_STOP_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd_stop && !cmd_valid) && !cmd_valid) |-> !mem_wr);  // R11
    AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd_valid && cmd_write && single_write) && !cmd_valid) |-> !mem_wr);  // R12
endmodule

// File: tb/sdr_burst_seq_bench.sv
module sdr_burst_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int COL_W = 8;
    localparam int NBYTE = 4;
    localparam int DW = 8 * NBYTE;
    localparam int DEPTH = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0, cmd_write = 1'b0, cmd_stop = 1'b0;
    logic [COL_W-1:0] cmd_col = '0;
    logic [1:0]       bl_sel = '0;
    logic             burst_interleave = 1'b0, cas_hi = 1'b0, single_write = 1'b0;
    logic [NBYTE-1:0] byte_mask = '0;
    logic [DW-1:0]    wr_data = '0;
    logic             wr_take, mem_rd, mem_wr, rd_valid;
    logic [COL_W-1:0] mem_col;
    logic [DW-1:0]    mem_wdata, mem_rdata, rd_data;
    logic [NBYTE-1:0] mem_be, rd_oe;

    logic [DW-1:0] arr [0:DEPTH-1];
    logic [DW-1:0] old [0:DEPTH-1];
    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdr_burst_seq #(.COL_W(COL_W), .NBYTE(NBYTE)) u_sdr_burst_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_col(cmd_col), .cmd_stop(cmd_stop), .bl_sel(bl_sel),
        .burst_interleave(burst_interleave), .cas_hi(cas_hi),
        .single_write(single_write), .byte_mask(byte_mask), .wr_data(wr_data),
        .wr_take(wr_take), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_col(mem_col),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata),
        .rd_valid(rd_valid), .rd_oe(rd_oe), .rd_data(rd_data)
    );

    // array model: registered read, byte-enabled write
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= arr[mem_col];
        if (mem_wr)
            for (int b = 0; b < NBYTE; b++)
                if (mem_be[b]) arr[mem_col][8*b +: 8] <= mem_wdata[8*b +: 8];
    end

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] s, input int i,
                                                 input int len, input bit il);
        int base = (int'(s) / len) * len;
        int lo = il ? ((int'(s) % len) ^ i) : (((int'(s) % len) + i) % len);
        return COL_W'(base + lo);
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                            input logic [NBYTE-1:0] m);
        logic [DW-1:0] r;
        for (int b = 0; b < NBYTE; b++) r[8*b +: 8] = m[b] ? o[8*b +: 8] : n[8*b +: 8];
        return r;
    endfunction

    task automatic idle_inputs();
        cmd_valid = 1'b0; cmd_write = 1'b0; cmd_stop = 1'b0; byte_mask = '0;
    endtask

    // read burst; stop_at < 0 means no stop, mask_beat < 0 means no mask
    task automatic t_read(input logic [COL_W-1:0] start, input int blsel, input bit il,
                          input bit hi, input int stop_at, input int mask_beat,
                          input logic [NBYTE-1:0] mval, input string col_tag);
        int len = 1 << blsel;
        int cl = hi ? 4 : 3;
        int nb = (stop_at >= 1 && stop_at < len) ? stop_at : len;
        string vtag = (stop_at >= 1) ? "R10" : "R7";
        bl_sel = 2'(blsel); burst_interleave = il; cas_hi = hi; single_write = 1'b0;
        for (int k = 0; k < len + cl + 2; k++) begin
            cmd_valid = (k == 0); cmd_write = 1'b0; cmd_col = start;
            cmd_stop = (k == stop_at);
            byte_mask = (k == mask_beat) ? mval : '0;
            #1;
            chk(mem_rd === (k < nb), "R2 read beat count", DW'(mem_rd), DW'(k < nb));
            if (k < nb)
                chk(mem_col === exp_col(start, k, len, il), col_tag, DW'(mem_col),
                    DW'(exp_col(start, k, len, il)));
            if (k >= cl && (k - cl) < nb) begin
                logic [NBYTE-1:0] m = ((k - cl) == mask_beat) ? mval : '0;
                logic [DW-1:0] e = merge(arr[exp_col(start, k - cl, len, il)], '0, ~m);
                chk(rd_valid === 1'b1, vtag, DW'(rd_valid), 1);
                chk(rd_data === e, (m != 0) ? "R8 masked data" : "R7 read data", rd_data, e);
                chk(rd_oe === ~m, "R8 lane drive", DW'(rd_oe), DW'(~m));
            end else begin
                chk(rd_valid === 1'b0, vtag, DW'(rd_valid), 0);
            end
            @(negedge clk);
        end
        idle_inputs();
    endtask

    task automatic t_write(input logic [COL_W-1:0] start, input int blsel, input bit il,
                           input bit single, input int stop_at, input int mask_beat,
                           input logic [NBYTE-1:0] mval);
        int len = 1 << blsel;
        int nb = single ? 1 : len;
        string tag = single ? "R12" : ((stop_at >= 1) ? "R11" : "R5");
        if (stop_at >= 1 && stop_at + 1 < nb) nb = stop_at + 1;
        for (int i = 0; i < DEPTH; i++) old[i] = arr[i];
        bl_sel = 2'(blsel); burst_interleave = il; single_write = single;
        for (int k = 0; k < len + 2; k++) begin
            cmd_valid = (k == 0); cmd_write = 1'b1; cmd_col = start;
            cmd_stop = (k == stop_at);
            byte_mask = (k == mask_beat) ? mval : '0;
            wr_data = DW'(32'hC0DE0000 + k * 32'h01010101) ^ DW'(start);
            #1;
            chk(mem_wr === (k < nb), tag, DW'(mem_wr), DW'(k < nb));
            chk(wr_take === (k < nb), "R5 write take", DW'(wr_take), DW'(k < nb));
            if (k < nb) begin
                chk(mem_col === exp_col(start, k, len, il), il ? "R4" : "R3",
                    DW'(mem_col), DW'(exp_col(start, k, len, il)));
                chk(mem_wdata === wr_data, "R5 write data", mem_wdata, wr_data);
                chk(mem_be === ~byte_mask, "R6 byte enable", DW'(mem_be), DW'(~byte_mask));
            end
            @(negedge clk);
        end
        idle_inputs(); single_write = 1'b0;
        for (int i = 0; i < len; i++) begin
            logic [COL_W-1:0] c = exp_col(start, i, len, il);
            logic [DW-1:0] wd = DW'(32'hC0DE0000 + i * 32'h01010101) ^ DW'(start);
            logic [NBYTE-1:0] m = (i == mask_beat) ? mval : '0;
            logic [DW-1:0] e = (i < nb) ? merge(old[c], wd, m) : old[c];
            chk(arr[c] === e, (i < nb) ? "R6 array content" : "R11 untouched", arr[c], e);
        end
    endtask

    task automatic t_back_to_back();
        // read of 8 at 0x20 cut at cycle 2 by read of 2 at 0x48, CL 3
        burst_interleave = 1'b0; cas_hi = 1'b0; single_write = 1'b0;
        for (int k = 0; k < 8; k++) begin
            cmd_valid = (k == 0 || k == 2); cmd_write = 1'b0;
            cmd_col = (k == 0) ? 8'h20 : 8'h48;
            bl_sel = (k == 0) ? 2'd3 : 2'd1;
            #1;
            if (k < 4) chk(mem_col === ((k < 2) ? 8'h20 + 8'(k) : 8'h46 + 8'(k)),
                           "R9 column", DW'(mem_col), DW'((k < 2) ? 8'h20 + 8'(k) : 8'h46 + 8'(k)));
            chk(mem_rd === (k < 4), "R9 issue", DW'(mem_rd), DW'(k < 4));
            if (k >= 3 && k < 7) begin
                logic [COL_W-1:0] c = (k < 5) ? 8'h1D + 8'(k) : 8'h43 + 8'(k);
                chk(rd_data === arr[c], "R9 data", rd_data, arr[c]);
            end else begin
                chk(rd_valid === 1'b0, "R9 valid", DW'(rd_valid), 0);
            end
            @(negedge clk);
        end
        // read of 4 at 0x50 cut at cycle 1 by a one-beat write at 0x70
        for (int i = 0; i < DEPTH; i++) old[i] = arr[i];
        for (int k = 0; k < 6; k++) begin
            cmd_valid = (k <= 1); cmd_write = (k == 1);
            cmd_col = (k == 0) ? 8'h50 : 8'h70;
            bl_sel = (k == 0) ? 2'd2 : 2'd0;
            wr_data = 32'h600DF00D;
            #1;
            chk(mem_rd === (k == 0), "R9 read cut", DW'(mem_rd), DW'(k == 0));
            chk(mem_wr === (k == 1), "R9 write start", DW'(mem_wr), DW'(k == 1));
            chk(rd_valid === (k == 3), "R9 one read beat", DW'(rd_valid), DW'(k == 3));
            if (k == 3) chk(rd_data === old[8'h50], "R9 data", rd_data, old[8'h50]);
            @(negedge clk);
        end
        idle_inputs();
        chk(arr[8'h70] === 32'h600DF00D, "R9 write landed", arr[8'h70], 32'h600DF00D);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++)
            arr[i] = {8'(i) ^ 8'h3C, 8'(i), ~8'(i), 8'h5A + 8'(i)};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(mem_rd === 1'b0, "R1 mem_rd", DW'(mem_rd), 0);
        chk(mem_wr === 1'b0, "R1 mem_wr", DW'(mem_wr), 0);
        chk(wr_take === 1'b0, "R1 wr_take", DW'(wr_take), 0);
        chk(rd_valid === 1'b0, "R1 rd_valid", DW'(rd_valid), 0);
        @(negedge clk);

        t_read(8'h11, 2, 1'b0, 1'b0, -1, -1, '0, "R3 seq col");
        t_read(8'h15, 3, 1'b0, 1'b1, -1, -1, '0, "R3 seq col");
        t_read(8'h15, 3, 1'b1, 1'b0, -1, -1, '0, "R4 xor col");
        t_read(8'h81, 2, 1'b1, 1'b1, -1, -1, '0, "R4 xor col");
        t_read(8'h33, 0, 1'b0, 1'b0, -1, -1, '0, "R2 len1 col");
        t_read(8'h3B, 1, 1'b1, 1'b1, -1, -1, '0, "R4 len2 col");
        t_read(8'h42, 2, 1'b0, 1'b0, -1, 2, 4'b0101, "R3 seq col");
        t_read(8'h47, 2, 1'b0, 1'b1, -1, 0, 4'b1000, "R3 seq col");
        t_read(8'h08, 3, 1'b0, 1'b0, 3, -1, '0, "R10 col");
        t_read(8'h08, 3, 1'b0, 1'b1, 3, -1, '0, "R10 col");
        t_write(8'h92, 2, 1'b0, 1'b0, -1, 1, 4'b1001);
        t_write(8'hA5, 3, 1'b1, 1'b0, -1, -1, '0);
        t_write(8'hB0, 3, 1'b0, 1'b0, 2, -1, '0);
        t_write(8'hC2, 2, 1'b0, 1'b1, -1, -1, '0);
        t_back_to_back();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule